// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers interrupt requests from a set of numbered sources and delivers them to a set of target contexts, such as harts at different privilege levels. Sources are numbered from 1; number 0 is reserved to mean "no interrupt". Each source has a programmable priority and a trigger mode, which is either level-high or rising-edge. Each context has its own per-source enable bitmap and a priority threshold. A per-source gateway holds a pending bit. The block raises a registered interrupt line for every context that has an eligible source.

Software uses a single word per context for two purposes. Reading that word claims the best eligible source: the read returns its ID and clears its pending bit in the same cycle. Writing the ID back to the same word completes the handling and reopens the gateway. The memory-mapped interface is a simple single-cycle request port. Read data comes back, registered, on the next cycle.

Top module: `plic_core`

## Requirements
- R1: After reset, every priority, enable, trigger-mode and threshold register reads 0, every context interrupt output is low, and a claim read returns 0.
- R2: The priority of source k is the word at byte address 4*k and holds PRIO_W bits; upper write bits are dropped. The word at address 0 always reads 0 and ignores writes.
- R3: The enable bitmap of context c starts at 0x2000 + 0x80*c. Source k is bit k%32 of word k/32 of that bitmap. Bit 0 of word 0 always reads 0.
- R4: A source is eligible for a context only when it is pending, enabled for that context, and its priority is strictly greater than that context's threshold. The threshold is the word at 0x200000 + 0x1000*c. The context's output goes high two clock edges after a level source rises.
- R5: A threshold of all ones (7 with 3-bit priorities) masks every source for that context. A priority of 0 masks a source for every context.
- R6: A read of the claim word of context c (0x200004 + 0x1000*c) returns the eligible source with the highest priority, with ties going to the lowest ID. The read returns 0 when nothing is eligible.
- R7: A claim clears the winner's pending bit in the same cycle. A second claim, from the same context or from another context, therefore never returns that source again until it pends anew.
- R8: After a claim, the gateway ignores its source until the claimed ID is written to a claim word. Writing an ID that is not in service has no effect.
- R9: In level mode, a source that is still high when its completion arrives becomes pending again.
- R10: The trigger-mode bitmap lives at 0x1100; source k is bit k%32 of word k/32, and 1 selects edge mode. In edge mode, one rising edge gives one request. An edge that arrives while the source is pending or in service is held and produces a request after completion. A source that stays high without a new edge does not request again.
- R11: Read data and its valid strobe appear on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NSRC | Request inputs; bit k is source k (range NSRC:1) |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| ctx_irq | output | NCTX | Registered interrupt line per context |

## Verification
The bench builds the block with 40 sources, 2 contexts and 3-bit priorities. With 40 sources, each enable bitmap and the trigger-mode bitmap spill into a second word, so the k/32 and k%32 field placement is exercised past bit 31. Having two contexts makes it possible to check that a claim from one context hides the source from the other. The 3-bit priority lets the all-ones threshold of 7 and the truncation of wide priority writes be checked directly.

// File: rtl/plic_pkg.sv
// Package: address map constants shared by the interrupt controller core.
// Assumes byte addressing with 32-bit registers.
package plic_pkg;
    localparam int MODE_BASE  = 32'h0000_1100;
    localparam int EN_BASE    = 32'h0000_2000;
    localparam int EN_STRIDE  = 32'h0000_0080;
    localparam int CTX_BASE   = 32'h0020_0000;
    localparam int CTX_STRIDE = 32'h0000_1000;
    localparam int CLAIM_OFS  = 4;
endpackage

// File: rtl/plic_gateway.sv
// Module: per-source gateway. Converts a level or rising-edge request into a
// pending bit, blocks the source between claim and completion, and holds
// one edge that arrives while the source is busy.
// Assumes claim is only pulsed while pending is high.
module plic_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic edge_mode,
    input  logic claim,
    input  logic done,
    output logic pending
);
    logic irq_d, busy, held, rise, trig, take;

    assign rise = irq_in & ~irq_d;
    assign trig = edge_mode ? (rise | held) : irq_in;
    assign take = ~claim & ~(done & busy) & ~pending & ~busy & trig;

    // Track pending/in-service state and the held edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_d   <= 1'b0;
            busy    <= 1'b0;
            held    <= 1'b0;
            pending <= 1'b0;
        end else begin
            irq_d <= irq_in;
            held  <= edge_mode & (held | rise) & ~take;
            if (claim) begin
                pending <= 1'b0;
                busy    <= 1'b1;
            end else if (done && busy) begin
                busy <= 1'b0;
            end else if (take) begin
                pending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/plic_target_arb.sv
// Module: per-context arbiter. Picks the eligible source with the highest
// priority, with the lowest ID winning ties; outputs 0 when none qualifies.
// Purely combinational; assumes source IDs 1..NSRC.
module plic_target_arb #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    localparam int IDW   = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]             pend,
    input  logic [NSRC:1]             en,
    input  logic [NSRC:1][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thr,
    output logic [IDW-1:0]            best_id
);
    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare keeps the lowest ID on ties.
    always_comb begin
        best_p  = '0;
        best_id = '0;
        for (int k = 1; k <= NSRC; k++) begin
            if (pend[k] && en[k] && prio[k] > thr && prio[k] > best_p) begin
                best_p  = prio[k];
                best_id = IDW'(k);
            end
        end
    end
endmodule

// File: rtl/plic_core.sv
// Module: interrupt controller top. Holds the register file, instantiates
// one gateway per source and one arbiter per context, and runs the
// claim/complete handshake. Assumes one access per cycle on the bus port.
module plic_core
    import plic_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_irq,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic [NCTX-1:0]   ctx_irq
);
    localparam int IDW = $clog2(NSRC + 1);

    logic [31:0]                a32;
    logic                       rd, wr;
    logic [NSRC:1][PRIO_W-1:0]  prio_q;
    logic [NSRC:1]              mode_q;
    logic [NCTX-1:0][NSRC:1]    en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;
    logic [NSRC:1]              pend_vec, claim_vec, done_vec;
    logic [NCTX-1:0][IDW-1:0]   best_id;
    logic [31:0]                rdata_d;

    assign a32 = 32'(bus_addr);
    assign rd  = bus_req & ~bus_we;
    assign wr  = bus_req & bus_we;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            mode_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (wr) begin
            for (int k = 1; k <= NSRC; k++) begin
                if (a32 == 32'(4 * k))
                    prio_q[k] <= bus_wdata[PRIO_W-1:0];
                if (a32 == 32'(MODE_BASE + 4 * (k / 32)))
                    mode_q[k] <= bus_wdata[k % 32];
            end
            for (int c = 0; c < NCTX; c++) begin
                for (int k = 1; k <= NSRC; k++) begin
                    if (a32 == 32'(EN_BASE + EN_STRIDE * c + 4 * (k / 32)))
                        en_q[c][k] <= bus_wdata[k % 32];
                end
                if (a32 == 32'(CTX_BASE + CTX_STRIDE * c))
                    thr_q[c] <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    // Claim and completion pulses toward the gateways.
    always_comb begin
        claim_vec = '0;
        done_vec  = '0;
        for (int c = 0; c < NCTX; c++) begin
            for (int k = 1; k <= NSRC; k++) begin
                if (rd && a32 == 32'(CTX_BASE + CTX_STRIDE * c + CLAIM_OFS)
                    && best_id[c] == IDW'(k))
                    claim_vec[k] = 1'b1;
                if (wr && a32 == 32'(CTX_BASE + CTX_STRIDE * c + CLAIM_OFS)
                    && bus_wdata == 32'(k))
                    done_vec[k] = 1'b1;
            end
        end
    end

    // Read data selection.
    always_comb begin
        rdata_d = '0;
        for (int k = 1; k <= NSRC; k++) begin
            if (a32 == 32'(4 * k))
                rdata_d[PRIO_W-1:0] = prio_q[k];
            if (a32 == 32'(MODE_BASE + 4 * (k / 32)))
                rdata_d[k % 32] = mode_q[k];
        end
        for (int c = 0; c < NCTX; c++) begin
            for (int k = 1; k <= NSRC; k++) begin
                if (a32 == 32'(EN_BASE + EN_STRIDE * c + 4 * (k / 32)))
                    rdata_d[k % 32] = en_q[c][k];
            end
            if (a32 == 32'(CTX_BASE + CTX_STRIDE * c))
                rdata_d[PRIO_W-1:0] = thr_q[c];
            if (a32 == 32'(CTX_BASE + CTX_STRIDE * c + CLAIM_OFS))
                rdata_d[IDW-1:0] = best_id[c];
        end
    end

    // Registered read response and context interrupt lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
            ctx_irq    <= '0;
        end else begin
            bus_rvalid <= rd;
            bus_rdata  <= rd ? rdata_d : '0;
            for (int c = 0; c < NCTX; c++)
                ctx_irq[c] <= (best_id[c] != '0);
        end
    end

    for (genvar g = 1; g <= NSRC; g++) begin : g_gw
        plic_gateway u_gw (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_in    (src_irq[g]),
            .edge_mode (mode_q[g]),
            .claim     (claim_vec[g]),
            .done      (done_vec[g]),
            .pending   (pend_vec[g])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_arb
        plic_target_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
            .pend    (pend_vec),
            .en      (en_q[c]),
            .prio    (prio_q),
            .thr     (thr_q[c]),
            .best_id (best_id[c])
        );
    end
endmodule

// File: rtl/plic_core_chk.sv
// Module: assertion checker for plic_core, attached by bind.
// Observes pending, claim, enable and threshold state plus the outputs.
module plic_core_chk #(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NSRC:1]               pend_vec,
    input logic [NSRC:1]               claim_vec,
    input logic [NCTX-1:0][NSRC:1]     en_q,
    input logic [NCTX-1:0][PRIO_W-1:0] thr_q,
    input logic [NCTX-1:0]             ctx_irq
);
    // R7: a single access claims at most one source.
    p_claim_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));

    // R7: only a pending source can be claimed.
    p_claim_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_vec & ~pend_vec) == '0);

    for (genvar k = 1; k <= NSRC; k++) begin : g_src
        // R7: the claimed source is no longer pending on the next cycle.
        p_claim_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            claim_vec[k] |=> !pend_vec[k]);
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        // R4: a raised line needs an enabled pending source one cycle earlier.
        p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ctx_irq[c] |-> $past(|(pend_vec & en_q[c])));
        // R5: an all-ones threshold keeps the line low.
        p_thr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(thr_q[c]) == '1) |-> !ctx_irq[c]);
    end
endmodule

bind plic_core plic_core_chk #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_vec  (pend_vec),
    .claim_vec (claim_vec),
    .en_q      (en_q),
    .thr_q     (thr_q),
    .ctx_irq   (ctx_irq)
);

// File: tb/sim_plic_core.sv
// Directed bench for plic_core: one task per scenario.
module sim_plic_core;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 40;
    localparam int NCTX = 2;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC:1]     src_irq = '0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rvalid;
    logic [31:0]       bus_rdata;
    logic [NCTX-1:0]   ctx_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    plic_core #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .ctx_irq(ctx_irq)
    );

    function automatic logic [31:0] a_en(int c, int w);
        return 32'h2000 + 32'h80 * c + 4 * w;
    endfunction
    function automatic logic [31:0] a_thr(int c);
        return 32'h20_0000 + 32'h1000 * c;
    endfunction
    function automatic logic [31:0] a_clm(int c);
        return 32'h20_0004 + 32'h1000 * c;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a[ADDR_W-1:0];
        @(negedge clk);
        bus_req = 1'b0;
        if (!bus_rvalid) begin
            n_chk++; n_bad++;
            $display("FAIL R11: rvalid got 0 expected 1");
        end
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_src(int k, logic v);
        @(negedge clk);
        src_irq[k] = v;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 ctx_irq", 32'(ctx_irq), 0);
        rd(32'h14, d);          chk("R1 prio5", d, 0);
        rd(a_en(1, 1), d);      chk("R1 enable", d, 0);
        rd(32'h1100, d);        chk("R1 mode", d, 0);
        rd(a_thr(0), d);        chk("R1 threshold", d, 0);
        rd(a_clm(0), d);        chk("R1 claim empty", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(32'h14, 32'hFFFF_FFFF);  rd(32'h14, d);   chk("R2 prio truncation", d, 7);
        wr(32'h0, 32'h5);           rd(32'h0, d);    chk("R2 prio0 fixed", d, 0);
        wr(a_en(1, 0), 32'hFFFF_FFFF); rd(a_en(1, 0), d); chk("R3 bit0 fixed", d, 32'hFFFF_FFFE);
        wr(a_en(1, 1), 32'h0000_0102); rd(a_en(1, 1), d); chk("R3 word1 fields", d, 32'h0000_0102);
        rd(a_en(0, 1), d); chk("R3 other context", d, 0);
        wr(a_en(1, 0), 0); wr(a_en(1, 1), 0); wr(32'h14, 0);
        rd(32'h14, d); chk("R2 prio clear", d, 0);
    endtask

    task automatic t_eligible();
        logic [31:0] d;
        wr(a_en(0, 0), 32'h8);      // source 3
        wr(32'hC, 2);
        wr(a_thr(0), 2);
        set_src(3, 1'b1);
        idle(3);
        chk("R4 equal prio below threshold", 32'(ctx_irq), 0);
        wr(a_thr(0), 1);
        idle(3);
        chk("R4 prio above threshold", 32'(ctx_irq), 1);
        wr(a_thr(0), 7);
        idle(3);
        chk("R5 threshold 7 masks", 32'(ctx_irq), 0);
        rd(a_clm(0), d); chk("R5 claim under mask", d, 0);
        wr(a_thr(0), 0); wr(32'hC, 0);
        idle(3);
        chk("R5 prio 0 masks", 32'(ctx_irq), 0);
        set_src(3, 1'b0);
        wr(32'hC, 1);
        idle(3);
        chk("R4 level pending kept", 32'(ctx_irq), 1);
        rd(a_clm(0), d); chk("R6 single claim", d, 3);
        wr(a_clm(0), 3);
        wr(32'hC, 0); wr(a_en(0, 0), 0);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        wr(a_en(0, 0), (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 9));
        wr(32'hC, 2); wr(32'h1C, 5); wr(32'h24, 5);
        set_src(3, 1'b1); set_src(7, 1'b1); set_src(9, 1'b1);
        idle(3);
        rd(a_clm(0), d); chk("R6 highest prio low id", d, 7);
        rd(a_clm(0), d); chk("R6 tie next id", d, 9);
        rd(a_clm(0), d); chk("R6 lower prio", d, 3);
        rd(a_clm(0), d); chk("R7 all claimed", d, 0);
        idle(2);
        chk("R8 line low while in service", 32'(ctx_irq), 0);
        wr(a_clm(0), 12);
        idle(2);
        rd(a_clm(0), d); chk("R8 wrong id ignored", d, 0);
        wr(a_clm(0), 9);
        idle(2);
        rd(a_clm(0), d); chk("R9 level re-pends", d, 9);
        set_src(3, 1'b0); set_src(7, 1'b0); set_src(9, 1'b0);
        wr(a_clm(0), 7); wr(a_clm(0), 3); wr(a_clm(0), 9);
        idle(2);
        rd(a_clm(0), d); chk("R9 low source stays idle", d, 0);
        wr(32'hC, 0); wr(32'h1C, 0); wr(32'h24, 0); wr(a_en(0, 0), 0);
    endtask

    task automatic t_two_ctx();
        logic [31:0] d;
        wr(a_en(0, 1), 32'h2); wr(a_en(1, 1), 32'h2);   // source 33
        wr(32'h84, 4);
        set_src(33, 1'b1);
        idle(3);
        chk("R4 both contexts raised", 32'(ctx_irq), 3);
        rd(a_clm(1), d); chk("R7 ctx1 claims", d, 33);
        rd(a_clm(0), d); chk("R7 ctx0 sees nothing", d, 0);
        idle(2);
        chk("R7 both lines low", 32'(ctx_irq), 0);
        set_src(33, 1'b0);
        wr(a_clm(1), 33);
        wr(a_en(0, 1), 0); wr(a_en(1, 1), 0); wr(32'h84, 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(32'h1100, 32'h1000);      // source 12 edge
        wr(32'h1104, 32'h4);         // source 34 edge
        rd(32'h1100, d); chk("R10 mode word0", d, 32'h1000);
        rd(32'h1104, d); chk("R10 mode word1", d, 32'h4);
        wr(a_en(0, 0), 32'h1000);
        wr(32'h30, 1);
        set_src(12, 1'b1); set_src(12, 1'b0);
        idle(2);
        rd(a_clm(0), d); chk("R10 edge claimed", d, 12);
        set_src(12, 1'b1); set_src(12, 1'b0);
        idle(2);
        rd(a_clm(0), d); chk("R8 edge blocked in service", d, 0);
        wr(a_clm(0), 12);
        idle(2);
        rd(a_clm(0), d); chk("R10 held edge after completion", d, 12);
        wr(a_clm(0), 12);
        idle(2);
        rd(a_clm(0), d); chk("R10 one request per edge", d, 0);
        set_src(12, 1'b1);
        idle(2);
        rd(a_clm(0), d); chk("R10 new edge", d, 12);
        wr(a_clm(0), 12);
        idle(3);
        rd(a_clm(0), d); chk("R10 steady high no request", d, 0);
        set_src(12, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        t_reset();
        t_regs();
        t_eligible();
        t_arb();
        t_two_ctx();
        t_edge();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule